// File: doc/BRIEF.md
# Self-Capturing Reference Pattern Checker

This block measures bit errors on an arbitrary repeating data pattern without any pattern preload. Software supplies only the pattern length in bits and pulses `start`. The block then stores the first incoming data words as its reference and compares every later word against that reference, with no gap between capture and compare. It accumulates the number of mismatching bits in a saturating counter.

Data arrives as words of `W` bits, one per cycle when `din_valid` is high. Each bit lane of the word acts as a sub-channel. The reference memory holds whole words only, so the stored length must be a multiple of `W` bits. If the requested length is not such a multiple, the pattern is recorded repeatedly until the stored length equals the least common multiple of the length and `W`. Because `W` is a power of two, the stored word count is the length shifted right by its trailing-zero count, capped at log2(`W`). For example, with W=64 a 127-bit pattern occupies 127 words and a 96-bit pattern occupies 3 words.

A configuration is rejected in two cases. The first is when the padded length does not fit the memory. The second is when the captured reference leaves every sub-channel constant, meaning all captured words are identical.

The controller is a four-state machine:
- IDLE is the state after reset.
- CAPTURE stores words into the reference memory.
- COMPARE checks incoming words against the stored reference.
- FAULT holds a rejected configuration.

Its transitions are:
- ARM: any state to CAPTURE, on `start` with a usable length.
- REJECT: any state to FAULT, on `start` with an unusable length.
- LOCK: CAPTURE to COMPARE, on the last capture word when the sub-channels vary.
- FLAT: CAPTURE to FAULT, on the last capture word when every sub-channel is constant.

Top module: `capref_cmp`

## Requirements
- R1: After reset, `busy`, `locked` and `cfg_err` are low and `err_cnt` is zero.
- R2: The padded word count is `pat_len >> min(ctz(pat_len), log2(W))`. `busy` rises on the edge that samples `start` and stays high until the edge that stores the last capture word. At most one of `busy`, `locked` and `cfg_err` is high at any time.
- R3: A length of zero, or a padded word count above `DEPTH`, raises `cfg_err` on the edge that samples `start`. This holds even when the raw length is no more than `W*DEPTH` bits. In that case nothing is captured, `busy` stays low and `err_cnt` stays at zero.
- R4: If all captured words are identical, `cfg_err` rises at the end of capture instead of `locked`. This includes the case of a single-word padded length.
- R5: `locked` rises on the edge that stores the last capture word. The very next valid word is compared against reference word 0. The compare pointer wraps back to word 0 after the last padded word.
- R6: Each compared valid word adds popcount(`din` XOR reference word) to `err_cnt`, and the new value is visible after that edge.
- R7: `err_cnt` saturates at 2^`CNT_W`-1 and does not wrap.
- R8: `start` clears `err_cnt` and re-arms capture from any state. A valid word in the same cycle as `start` is neither captured nor compared.
- R9: Cycles with `din_valid` low neither advance capture or compare nor change `err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: latch length, clear count, begin capture |
| pat_len | input | LEN_W | Pattern length in bits |
| din_valid | input | 1 | `din` carries a word this cycle |
| din | input | W | Received data word, one bit per sub-channel |
| busy | output | 1 | Reference capture in progress |
| locked | output | 1 | Reference stored, comparing |
| cfg_err | output | 1 | Configuration rejected |
| err_cnt | output | CNT_W | Saturating count of mismatching bits |

## Verification
Two functions can collide in one cycle: a `start` pulse and a valid data word that would otherwise be compared, or that would be the first word captured. The bench raises `start` together with `din_valid` while the block is locked, using a word that differs from the pattern that follows. It then expects `err_cnt` to read zero one edge later. A following run of exact-match words must also produce zero errors, which can only happen if the colliding word was not stored as reference word 0.

// File: rtl/capref_pkg.sv
package capref_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COMPARE = 2'd2,
        ST_FAULT   = 2'd3
    } cap_state_e;
endpackage

// File: rtl/capref_len.sv
// Padded length: words = len >> min(ctz(len), log2(W)); reject zero or oversize.
module capref_len #(
    parameter int W     = 64,
    parameter int DEPTH = 1024,
    parameter int LEN_W = 24
) (
    input  logic [LEN_W-1:0]         len,
    output logic [$clog2(DEPTH)-1:0] last_idx,
    output logic                     bad
);
    localparam int LOG2W = $clog2(W);
    localparam int TZ_W  = $clog2(LOG2W + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [TZ_W-1:0]  tz;
    logic [LEN_W-1:0] words;

    always_comb begin
        tz = TZ_W'(LOG2W);
        for (int i = LOG2W - 1; i >= 0; i--) begin
            if (len[i]) tz = TZ_W'(i);
        end
        words    = len >> tz;
        bad      = (len == '0) || (words > LEN_W'(DEPTH));
        last_idx = PTR_W'(words - LEN_W'(1));
    end
endmodule

// File: rtl/capref_mem.sv
module capref_mem #(
    parameter int W     = 64,
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/capref_acc.sv
// Adds popcount(a ^ b) to a saturating counter.
module capref_acc #(
    parameter int W     = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [CNT_W-1:0] cnt
);
    localparam int PC_W = $clog2(W + 1);

    logic [W-1:0]     diff;
    logic [PC_W-1:0]  pc;
    logic [CNT_W:0]   sum;

    always_comb begin
        diff = a ^ b;
        pc   = '0;
        for (int i = 0; i < W; i++) pc = pc + PC_W'(diff[i]);
        sum  = {1'b0, cnt} + (CNT_W + 1)'(pc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (en)    cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/capref_cmp.sv
module capref_cmp
    import capref_pkg::*;
#(
    parameter int W     = 64,
    parameter int DEPTH = 1024,
    parameter int LEN_W = 24,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pat_len,
    input  logic             din_valid,
    input  logic [W-1:0]     din,
    output logic             busy,
    output logic             locked,
    output logic             cfg_err,
    output logic [CNT_W-1:0] err_cnt
);
    localparam int PTR_W = $clog2(DEPTH);

    cap_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, last_q, len_last;
    logic [W-1:0]     first_q, ref_word;
    logic             eq_q, len_bad, wrap, flat, in_cap, in_cmp;

    capref_len #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W)) len_i (
        .len      (pat_len),
        .last_idx (len_last),
        .bad      (len_bad)
    );

    assign in_cap = (state_q == ST_CAPTURE);
    assign in_cmp = (state_q == ST_COMPARE);
    assign wrap   = (ptr_q == last_q);
    assign flat   = eq_q && ((ptr_q == '0) || (din == first_q));

    capref_mem #(.W(W), .DEPTH(DEPTH)) mem_i (
        .clk   (clk),
        .we    (in_cap && din_valid && !start),
        .addr  (ptr_q),
        .wdata (din),
        .rdata (ref_word)
    );

    capref_acc #(.W(W), .CNT_W(CNT_W)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (in_cmp && din_valid && !start),
        .a     (din),
        .b     (ref_word),
        .cnt   (err_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: ARM / REJECT from any state, LOCK / FLAT out of CAPTURE
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = len_bad ? ST_FAULT : ST_CAPTURE;
        end else begin
            unique case (state_q)
                ST_CAPTURE: if (din_valid && wrap) state_d = flat ? ST_FAULT : ST_COMPARE;
                ST_IDLE, ST_COMPARE, ST_FAULT: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        locked  = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_CAPTURE: busy    = 1'b1;
            ST_COMPARE: locked  = 1'b1;
            ST_FAULT:   cfg_err = 1'b1;
            default:    ;
        endcase
    end

    // Pointer, latched length and flat-pattern tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            last_q  <= '0;
            first_q <= '0;
            eq_q    <= 1'b1;
        end else if (start) begin
            ptr_q  <= '0;
            last_q <= len_last;
            eq_q   <= 1'b1;
        end else if (din_valid && (in_cap || in_cmp)) begin
            ptr_q <= wrap ? '0 : ptr_q + PTR_W'(1);
            if (in_cap) begin
                if (ptr_q == '0)          first_q <= din;
                else if (din != first_q)  eq_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/capref_chk.sv
module capref_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             din_valid,
    input logic             busy,
    input logic             locked,
    input logic             cfg_err,
    input logic [CNT_W-1:0] err_cnt
);
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, locked, cfg_err})); // R2
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !start) |=> $stable(err_cnt)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> (err_cnt >= $past(err_cnt))); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (err_cnt == '0)); // R8
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !din_valid && !start) |=> $stable(err_cnt)); // R9
endmodule

bind capref_cmp capref_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .din_valid (din_valid),
    .busy      (busy),
    .locked    (locked),
    .cfg_err   (cfg_err),
    .err_cnt   (err_cnt)
);

// File: tb/capref_cmp_tb_top.sv
module capref_cmp_tb_top;
    localparam int W = 64, DEPTH = 1024, LEN_W = 24, CNT_W = 16;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0, start = 0, din_valid = 0, tb_cmp = 0;
    logic [LEN_W-1:0] pat_len = '0;
    logic [W-1:0] din = '0;
    logic busy, locked, cfg_err;
    logic [CNT_W-1:0] err_cnt;

    int total = 0, bad = 0, exp_cnt = 0, idx = 0;
    int exp_q[$];
    logic [W-1:0] ref_m[$];

    always #10 clk = ~clk;

    capref_cmp #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (.*);

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected count for each compared word
    always @(posedge clk) begin
        if (tb_cmp && din_valid && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            #5 check("R6 err_cnt", err_cnt, e);
        end
    end

    task automatic arm(int len);
        start = 1; pat_len = LEN_W'(len); din_valid = 0; tb_cmp = 0;
        @(negedge clk);
        start = 0;
        ref_m.delete(); idx = 0; exp_cnt = 0;
    endtask

    task automatic put_cap(logic [W-1:0] w);
        din = w; din_valid = 1; tb_cmp = 0; ref_m.push_back(w);
        @(negedge clk);
    endtask

    task automatic put_cmp(logic [W-1:0] w);
        int pc;
        pc = $countones(w ^ ref_m[idx]);
        idx = (idx + 1) % ref_m.size();
        exp_cnt = (exp_cnt + pc > MAXC) ? MAXC : exp_cnt + pc;
        exp_q.push_back(exp_cnt);
        din = w; din_valid = 1; tb_cmp = 1;
        @(negedge clk);
    endtask

    task automatic gap();
        din_valid = 0; tb_cmp = 0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] p [5];
        for (int i = 0; i < 5; i++) p[i] = {32'hA5C3_0000 + 32'(i * 7), 32'h1234_5678 ^ 32'(i << 4)};
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy", busy, 0); check("R1 locked", locked, 0);
        check("R1 cfg_err", cfg_err, 0); check("R1 err_cnt", err_cnt, 0);

        // R2: 160 bits -> 5 words, with a gap mid-capture (R9)
        arm(160);
        check("R2 busy after start", busy, 1);
        put_cap(p[0]); put_cap(p[1]);
        gap(); gap();
        check("R9 busy held over gap", busy, 1);
        put_cap(p[2]); put_cap(p[3]);
        check("R2 busy before last word", busy, 1);
        put_cap(p[4]);
        check("R2 busy after last word", busy, 0);
        check("R5 locked after last word", locked, 1);

        // R5/R6: compare, wrap across 5 words, varied error patterns
        for (int k = 0; k < 5; k++) put_cmp(p[k]);
        put_cmp(p[0] ^ 64'h1);
        put_cmp(p[1] ^ 64'hF0);
        gap();
        check("R9 err_cnt held over gap", err_cnt, exp_cnt);
        for (int k = 2; k < 5; k++) put_cmp(p[k] ^ 64'h8000_0000_0000_0003);
        put_cmp(p[0]);
        put_cmp(~p[1]);
        gap();
        check("R5 wrap total", err_cnt, exp_cnt);

        // R8: start collides with a valid word while locked
        start = 1; pat_len = 24'd96; din = 64'hDEAD_BEEF_0BAD_F00D; din_valid = 1; tb_cmp = 0;
        @(negedge clk);
        start = 0; din_valid = 0;
        ref_m.delete(); idx = 0; exp_cnt = 0;
        check("R8 err_cnt cleared", err_cnt, 0);
        check("R8 busy re-armed", busy, 1);
        put_cap(p[1]); put_cap(p[2]); put_cap(p[3]);
        check("R8 locked after 3 words", locked, 1);
        for (int k = 0; k < 6; k++) put_cmp(p[(k % 3) + 1]);
        gap();
        check("R8 colliding word not captured", err_cnt, 0);

        // R3: rejected lengths
        arm(0);
        check("R3 zero length", cfg_err, 1);
        check("R3 busy low", busy, 0);
        arm(1025);
        check("R3 padded overflow", cfg_err, 1);
        put_cap(p[0] ^ 64'hFF); gap();
        check("R3 no count in fault", err_cnt, 0);
        arm(65536);
        check("R3 full depth accepted", busy, 1);

        // R4: flat captures
        arm(64);
        put_cap(p[0]); gap();
        check("R4 single word flat", cfg_err, 1);
        check("R4 not locked", locked, 0);
        arm(128);
        put_cap(p[2]); put_cap(p[2]); gap();
        check("R4 identical words flat", cfg_err, 1);

        // R7: saturation with 192 bits -> 3 words
        arm(192);
        put_cap(p[0]); put_cap(p[1]); put_cap(p[2]);
        check("R7 locked", locked, 1);
        for (int k = 0; k < 1030; k++) put_cmp(~p[k % 3]);
        gap();
        check("R7 saturated", err_cnt, MAXC);

        gap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule